// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is a bus master on the host side. It runs a scan across a parallel-bus successive-approximation converter. The converter is controlled by active-low chip-select, write and read strobes, and it reports completion on an active-low interrupt line. A single start pulse begins the scan. The sequencer then takes a list of NUM_ENTRIES eight-bit channel configuration codes in order. For each code it does the following:

- selects the converter and writes the code, which starts a conversion;
- waits for the conversion to finish;
- reads the eight-bit result;
- releases the select;
- writes the result into a result register file at the latched base address plus the entry index.

Single-ended scanning of eight inputs uses codes 08h through 0Fh. Two differential pairs use 00h and 02h.

There are two ways to wait for completion, chosen at start time:

- **Polling:** watch the synchronized interrupt line and read once it goes low. A cycle-count guard aborts the scan if the interrupt never comes.
- **Fixed delay:** wait a fixed number of clock cycles after the write strobe and ignore the interrupt entirely.

All strobe widths and gaps are parameters in clock cycles. Elaboration-time checks make sure these widths meet the converter's minimum times at the stated clock period.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset cs_n, wr_n and rd_n are 1, db_oe, done, err, busy and mem_we are 0.
- R2: A start pulse while idle drives cs_n low and db_oe high with the entry code on db_out, for exactly SETUP_CYC cycles before wr_n falls.
- R3: wr_n is low for exactly WR_LOW_CYC cycles. During those cycles and the one cycle after wr_n rises, db_out holds the code with db_oe high and cs_n low. wr_n and rd_n are never low at the same time, and neither is low while cs_n is high.
- R4: Entry n (code_list[n], n from 0 to NUM_ENTRIES-1) is written on the n-th write strobe of a scan, in increasing order of n.
- R5: In polling mode (poll_mode = 1 at start) rd_n stays high while intr_n is high. rd_n falls at most SYNC_STAGES+2 cycles after intr_n goes low.
- R6: In delay mode (poll_mode = 0 at start) rd_n falls exactly DELAY_CYC+1 cycles after wr_n rises, whatever intr_n does.
- R7: rd_n is low for exactly RD_LOW_CYC cycles. The value stored is db_in as seen in the last of those cycles.
- R8: The result of entry n is written in a one-cycle mem_we pulse at mem_addr = base_addr + n (modulo 2^AW). cs_n is high in that cycle.
- R9: cs_n goes high after every read, before the next entry's write, so a full scan has NUM_ENTRIES select releases.
- R10: done is high for exactly one cycle, in the cycle after the last store. busy is low from then on.
- R11: In polling mode, if intr_n stays high for TIMEOUT_CYC cycles of waiting, the scan aborts. err is set with cs_n high and busy low, and no further read, store or done follows. err stays set until the next accepted start clears it.
- R12: A start pulse while busy is ignored: the running scan keeps its order, addresses and number of stores.
- R13: poll_mode and base_addr are sampled only when a start is accepted. Changing them during a scan has no effect on that scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a scan |
| poll_mode | input | 1 | 1: wait on interrupt, 0: fixed delay (sampled at start) |
| base_addr | input | AW | First result address (sampled at start) |
| code_list | input | NUM_ENTRIES x 8 | Configuration code per entry, entry 0 in the low byte |
| cs_n | output | 1 | Converter select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| db_oe | output | 1 | Drive enable for db_out onto the shared bus |
| db_out | output | 8 | Configuration code driven to the converter |
| db_in | input | 8 | Data bus value read from the converter |
| intr_n | input | 1 | Conversion-complete flag, active low, asynchronous |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse after the last store |
| err | output | 1 | Polling timeout occurred (sticky until next start) |
| mem_we | output | 1 | Result file write enable |
| mem_addr | output | AW | Result file write address |
| mem_wdata | output | 8 | Result data |

## Verification
Most wrong internal states show up at the ports within one entry.

- A bad dwell counter changes the width of the very next strobe, or the gap between the write and read strobes. That width is measured directly on wr_n and rd_n.
- A bad entry index shows as a wrong code on db_out during the next setup phase. It also shows as a wrong mem_addr on the store a few hundred cycles later.
- A mode or base that was not held at start shows up when the scan ends. It appears as a write-to-read gap that does not match the requested mode, or as results landing in the region of the new base.
- A broken abort shows as reads, stores or a done pulse after err rises, or as the select left asserted.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WRLO,
      ST_HOLD,
      ST_WAIT,
      ST_RDLO,
      ST_STORE,
      ST_DONE
   } seq_state_t;

   function automatic int max2(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= {STAGES{RST_VAL}};
            end else begin
               sh_q[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

   // R3
   expired_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero);

endmodule

// File: rtl/adcseq_bus_drv.sv
module adcseq_bus_drv
   import adcseq_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  seq_state_t    nxt,
   input  logic [DW-1:0] code,
   output logic          cs_n,
   output logic          wr_n,
   output logic          rd_n,
   output logic          db_oe,
   output logic [DW-1:0] db_out
);

   logic sel_on;
   logic drive_on;

   assign sel_on   = (nxt == ST_SETUP) || (nxt == ST_WRLO) || (nxt == ST_HOLD) ||
                     (nxt == ST_WAIT)  || (nxt == ST_RDLO);
   assign drive_on = (nxt == ST_SETUP) || (nxt == ST_WRLO) || (nxt == ST_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n   <= 1'b1;
         wr_n   <= 1'b1;
         rd_n   <= 1'b1;
         db_oe  <= 1'b0;
         db_out <= '0;
      end else begin
         cs_n  <= !sel_on;
         wr_n  <= (nxt != ST_WRLO);
         rd_n  <= (nxt != ST_RDLO);
         db_oe <= drive_on;
         if (nxt == ST_SETUP) begin
            db_out <= code;
         end
      end
   end

   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> ($stable(db_out) && db_oe && !cs_n));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adcseq_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int AW          = 8,
   parameter int CLK_NS      = 10,
   parameter int SETUP_CYC   = 10,
   parameter int WR_LOW_CYC  = 16,
   parameter int RD_LOW_CYC  = 25,
   parameter int DELAY_CYC   = 5000,
   parameter int TIMEOUT_CYC = 20000,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        poll_mode,
   input  logic [AW-1:0]               base_addr,
   input  logic [NUM_ENTRIES-1:0][7:0] code_list,
   output logic                        cs_n,
   output logic                        wr_n,
   output logic                        rd_n,
   output logic                        db_oe,
   output logic [7:0]                  db_out,
   input  logic [7:0]                  db_in,
   input  logic                        intr_n,
   output logic                        busy,
   output logic                        done,
   output logic                        err,
   output logic                        mem_we,
   output logic [AW-1:0]               mem_addr,
   output logic [7:0]                  mem_wdata
);

   localparam int IW   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
   localparam int MAXV = max2(max2(SETUP_CYC, WR_LOW_CYC),
                              max2(RD_LOW_CYC, max2(DELAY_CYC, TIMEOUT_CYC)));
   localparam int CW   = $clog2(MAXV + 1);

   // elaboration-time parameter checks
   generate
      if (NUM_ENTRIES < 1 || NUM_ENTRIES > 8) begin : g_bad_len
         $error("NUM_ENTRIES must be 1..8");
      end
      if (AW < IW) begin : g_bad_aw
         $error("AW too narrow for the entry index");
      end
      if (WR_LOW_CYC * CLK_NS < 150) begin : g_bad_wr
         $error("write strobe shorter than 150 ns");
      end
      if (SETUP_CYC * CLK_NS < 100) begin : g_bad_setup
         $error("data setup shorter than 100 ns");
      end
      if (RD_LOW_CYC * CLK_NS < 250) begin : g_bad_rd
         $error("read strobe shorter than data access time");
      end
      if (DELAY_CYC < 1 || TIMEOUT_CYC < 1) begin : g_bad_wait
         $error("wait windows must be at least one cycle");
      end
      if (WR_LOW_CYC + 1 <= SYNC_STAGES) begin : g_bad_sync
         $error("interrupt synchronizer slower than write phase");
      end
   endgenerate

   seq_state_t    state_q, state_d;
   logic [IW-1:0] idx_q, idx_d;
   logic          mode_q;
   logic [AW-1:0] base_q;
   logic [7:0]    data_q;
   logic          err_q;
   logic          intr_s;
   logic          tmr_zero;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          abort;
   logic          capture;
   logic          accept;

   adcseq_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (intr_n),
      .q     (intr_s)
   );

   function automatic logic [CW-1:0] dwell(seq_state_t s, logic poll);
      case (s)
         ST_SETUP: return CW'(SETUP_CYC - 1);
         ST_WRLO:  return CW'(WR_LOW_CYC - 1);
         ST_RDLO:  return CW'(RD_LOW_CYC - 1);
         ST_WAIT:  return poll ? CW'(TIMEOUT_CYC - 1) : CW'(DELAY_CYC - 1);
         default:  return '0;
      endcase
   endfunction

   assign accept = (state_q == ST_IDLE) && start;

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      abort   = 1'b0;
      capture = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d = ST_SETUP;
               idx_d   = '0;
            end
         end
         ST_SETUP: if (tmr_zero) state_d = ST_WRLO;
         ST_WRLO:  if (tmr_zero) state_d = ST_HOLD;
         ST_HOLD:  state_d = ST_WAIT;
         ST_WAIT: begin
            if (mode_q) begin
               if (!intr_s) begin
                  state_d = ST_RDLO;
               end else if (tmr_zero) begin
                  state_d = ST_IDLE;
                  abort   = 1'b1;
               end
            end else if (tmr_zero) begin
               state_d = ST_RDLO;
            end
         end
         ST_RDLO: begin
            if (tmr_zero) begin
               state_d = ST_STORE;
               capture = 1'b1;
            end
         end
         ST_STORE: begin
            if (idx_q == IW'(NUM_ENTRIES - 1)) begin
               state_d = ST_DONE;
            end else begin
               idx_d   = idx_q + 1'b1;
               state_d = ST_SETUP;
            end
         end
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   assign tmr_load = (state_d != state_q);
   assign tmr_val  = dwell(state_d, mode_q);

   adcseq_timer #(
      .CW (CW)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         mode_q  <= 1'b0;
         base_q  <= '0;
         data_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         if (accept) begin
            mode_q <= poll_mode;
            base_q <= base_addr;
         end
         if (capture) begin
            data_q <= db_in;
         end
         if (accept) begin
            err_q <= 1'b0;
         end else if (abort) begin
            err_q <= 1'b1;
         end
      end
   end

   adcseq_bus_drv #(
      .DW (8)
   ) i_bus (
      .clk    (clk),
      .rst_n  (rst_n),
      .nxt    (state_d),
      .code   (code_list[idx_d]),
      .cs_n   (cs_n),
      .wr_n   (wr_n),
      .rd_n   (rd_n),
      .db_oe  (db_oe),
      .db_out (db_out)
   );

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign err       = err_q;
   assign mem_we    = (state_q == ST_STORE);
   assign mem_addr  = base_q + AW'(idx_q);
   assign mem_wdata = data_q;

   // R3
   strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n || !rd_n) |-> !cs_n);

   // R5
   poll_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n) && mode_q) |-> !$past(intr_s));

   // R8
   store_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> cs_n);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_we));

   // R11
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (cs_n && !busy && !done));

endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

   localparam int CLK_PERIOD = 10;
   localparam int NUM        = 8;
   localparam int AW         = 8;
   localparam int SETUP      = 10;
   localparam int WRLO       = 16;
   localparam int RDLO       = 25;
   localparam int DELAY      = 600;
   localparam int TMO        = 1000;
   localparam int SYNC       = 2;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                start;
   logic                poll_mode;
   logic [AW-1:0]       base_addr;
   logic [NUM-1:0][7:0] code_list;
   logic                cs_n, wr_n, rd_n, db_oe;
   logic [7:0]          db_out;
   logic [7:0]          db_in;
   logic                intr_n;
   logic                busy, done, err, mem_we;
   logic [AW-1:0]       mem_addr;
   logic [7:0]          mem_wdata;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_scan_seq #(
      .NUM_ENTRIES (NUM),
      .AW          (AW),
      .CLK_NS      (CLK_PERIOD),
      .SETUP_CYC   (SETUP),
      .WR_LOW_CYC  (WRLO),
      .RD_LOW_CYC  (RDLO),
      .DELAY_CYC   (DELAY),
      .TIMEOUT_CYC (TMO),
      .SYNC_STAGES (SYNC)
   ) i_adc_scan_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .poll_mode (poll_mode),
      .base_addr (base_addr),
      .code_list (code_list),
      .cs_n      (cs_n),
      .wr_n      (wr_n),
      .rd_n      (rd_n),
      .db_oe     (db_oe),
      .db_out    (db_out),
      .db_in     (db_in),
      .intr_n    (intr_n),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   // ---------------- converter model ----------------
   bit         respond = 1'b1;
   int         conv_cyc = 400;
   logic [7:0] salt = 8'h00;
   logic [7:0] code_m, result_m;
   logic       pw_m;
   int         conv_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         intr_n   <= 1'b1;
         conv_cnt <= 0;
         pw_m     <= 1'b1;
         result_m <= 8'h00;
         code_m   <= 8'h00;
      end else begin
         pw_m <= wr_n;
         if (!wr_n && !cs_n) begin
            intr_n   <= 1'b1;
            conv_cnt <= 0;
         end else if (wr_n && !pw_m && !cs_n) begin
            code_m   <= db_out;
            conv_cnt <= conv_cyc;
         end else if (conv_cnt > 0) begin
            conv_cnt <= conv_cnt - 1;
            if (conv_cnt == 1) begin
               result_m <= code_m ^ salt;
               if (respond) intr_n <= 1'b0;
            end
         end
         if (!rd_n && !cs_n) intr_n <= 1'b1;
      end
   end

   assign db_in = (!rd_n && !cs_n) ? result_m : 8'hEE;

   // ---------------- result memory model ----------------
   logic [7:0] bmem [0:255];
   int         we_cnt;

   initial begin
      for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
   end

   always @(posedge clk) begin
      if (mem_we) begin
         bmem[mem_addr] <= mem_wdata;
         we_cnt <= we_cnt + 1;
      end
   end

   // ---------------- bus monitor (away from the active edge) ----------------
   logic       pw = 1'b1, pr = 1'b1, pc = 1'b1, pi = 1'b1;
   int         wr_run, rd_run, pre_run, gap_run, lat_run;
   int         wr_min, wr_max, rd_min, rd_max, pre_min, pre_max;
   int         gap_min, gap_max, lat_min, lat_max;
   int         n_rd, releases, done_cnt, ncodes;
   bit         after_wr, in_gap, lat_on, data_bad, cs_bad;
   logic [7:0] wr_data;
   logic [7:0] codes_seen [0:15];

   task automatic clr_stats();
      wr_run = 0; rd_run = 0; pre_run = 0; gap_run = 0; lat_run = 0;
      wr_min = 1 << 30; wr_max = 0; rd_min = 1 << 30; rd_max = 0;
      pre_min = 1 << 30; pre_max = 0; gap_min = 1 << 30; gap_max = 0;
      lat_min = 1 << 30; lat_max = 0;
      n_rd = 0; releases = 0; done_cnt = 0; ncodes = 0;
      after_wr = 0; in_gap = 0; lat_on = 0; data_bad = 0; cs_bad = 0;
      we_cnt = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (((!wr_n) || (!rd_n)) && cs_n) cs_bad = 1;
         if (!wr_n && !rd_n) cs_bad = 1;
         if (done) done_cnt++;
         if (!wr_n) begin
            if (pw) begin
               wr_data = db_out;
               if (pre_run < pre_min) pre_min = pre_run;
               if (pre_run > pre_max) pre_max = pre_run;
               after_wr = 1;
            end else if (db_out !== wr_data || db_oe !== 1'b1) begin
               data_bad = 1;
            end
            wr_run++;
         end else if (!pw) begin
            if (wr_run < wr_min) wr_min = wr_run;
            if (wr_run > wr_max) wr_max = wr_run;
            wr_run = 0;
            if (ncodes < 16) codes_seen[ncodes] = wr_data;
            ncodes++;
            gap_run = 0;
            in_gap = 1;
            if (db_oe !== 1'b1 || db_out !== wr_data || cs_n) data_bad = 1;
         end
         if (!cs_n && wr_n && !after_wr) pre_run++;
         if (in_gap && wr_n && rd_n && !cs_n) gap_run++;
         if (!rd_n) begin
            if (pr) begin
               if (gap_run < gap_min) gap_min = gap_run;
               if (gap_run > gap_max) gap_max = gap_run;
               in_gap = 0;
               n_rd++;
            end
            rd_run++;
         end else if (!pr) begin
            if (rd_run < rd_min) rd_min = rd_run;
            if (rd_run > rd_max) rd_max = rd_run;
            rd_run = 0;
         end
         if (cs_n && !pc) begin
            releases++;
            after_wr = 0;
            in_gap = 0;
         end
         if (cs_n) pre_run = 0;
         if (!intr_n && pi) begin
            lat_on = 1;
            lat_run = 0;
         end
         if (lat_on) begin
            lat_run++;
            if (!rd_n) begin
               if (lat_run < lat_min) lat_min = lat_run;
               if (lat_run > lat_max) lat_max = lat_run;
               lat_on = 0;
            end
         end
      end
      pw = wr_n; pr = rd_n; pc = cs_n; pi = intr_n;
   end

   // ---------------- check helpers ----------------
   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_end(input int limit);
      for (int c = 0; c < limit; c++) begin
         @(negedge clk);
         if (done_cnt > 0 || err) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_scan_common(input logic [NUM-1:0][7:0] cl, input logic [AW-1:0] base,
                                  input logic [7:0] slt, input string tag);
      check(pre_min == SETUP && pre_max == SETUP, {tag, " R2 setup cycles"}, pre_max, SETUP);
      check(wr_min == WRLO && wr_max == WRLO, {tag, " R3 wr_n low width"}, wr_max, WRLO);
      check(!data_bad && !cs_bad, {tag, " R3 data/strobe discipline"}, int'(data_bad) + int'(cs_bad), 0);
      check(ncodes == NUM, {tag, " R4 write count"}, ncodes, NUM);
      for (int n = 0; n < NUM; n++) begin
         check(codes_seen[n] == cl[n], {tag, " R4 code order"}, codes_seen[n], cl[n]);
      end
      check(rd_min == RDLO && rd_max == RDLO, {tag, " R7 rd_n low width"}, rd_max, RDLO);
      check(we_cnt == NUM, {tag, " R8 store count"}, we_cnt, NUM);
      for (int n = 0; n < NUM; n++) begin
         check(bmem[8'(base + n)] == (cl[n] ^ slt), {tag, " R8 R7 stored result"},
               bmem[8'(base + n)], cl[n] ^ slt);
      end
      check(releases == NUM, {tag, " R9 select releases"}, releases, NUM);
      check(done_cnt == 1 && !busy && !err, {tag, " R10 single done pulse"}, done_cnt, 1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(cs_n && wr_n && rd_n, "R1 strobes idle", {cs_n, wr_n, rd_n}, 7);
      check(!db_oe && !done && !err && !busy && !mem_we, "R1 flags clear",
            {db_oe, done, err, busy, mem_we}, 0);
   endtask

   task automatic t_poll_scan();
      logic [NUM-1:0][7:0] cl;
      for (int n = 0; n < NUM; n++) cl[n] = 8'h08 + 8'(n);
      code_list = cl; base_addr = 8'h20; poll_mode = 1'b1;
      salt = 8'h5A; respond = 1'b1; conv_cyc = 400;
      clr_stats();
      pulse_start();
      wait_end(20000);
      chk_scan_common(cl, 8'h20, 8'h5A, "poll");
      check(gap_min >= conv_cyc, "R5 no read before interrupt", gap_min, conv_cyc);
      check(lat_max <= SYNC + 2 && lat_min >= 1, "R5 read latency after interrupt", lat_max, SYNC + 2);
   endtask

   task automatic t_delay_silent();
      logic [NUM-1:0][7:0] cl;
      cl = {8'h03, 8'h01, 8'h08, 8'h0F, 8'h02, 8'h00, 8'h02, 8'h00};
      code_list = cl; base_addr = 8'hC0; poll_mode = 1'b0;
      salt = 8'h33; respond = 1'b0; conv_cyc = 400;
      clr_stats();
      pulse_start();
      wait_end(20000);
      chk_scan_common(cl, 8'hC0, 8'h33, "delay-silent");
      check(gap_min == DELAY + 1 && gap_max == DELAY + 1, "R6 fixed gap, interrupt absent", gap_max, DELAY + 1);
   endtask

   task automatic t_delay_early();
      logic [NUM-1:0][7:0] cl;
      for (int n = 0; n < NUM; n++) cl[n] = 8'h0F - 8'(n);
      code_list = cl; base_addr = 8'h60; poll_mode = 1'b0;
      salt = 8'hC3; respond = 1'b1; conv_cyc = 150;
      clr_stats();
      pulse_start();
      wait_end(20000);
      chk_scan_common(cl, 8'h60, 8'hC3, "delay-early");
      check(gap_min == DELAY + 1 && gap_max == DELAY + 1, "R6 fixed gap, early interrupt", gap_max, DELAY + 1);
   endtask

   task automatic t_timeout();
      logic [NUM-1:0][7:0] cl;
      for (int n = 0; n < NUM; n++) cl[n] = 8'h08 + 8'(n);
      code_list = cl; base_addr = 8'hA0; poll_mode = 1'b1;
      salt = 8'h11; respond = 1'b0; conv_cyc = 100;
      clr_stats();
      pulse_start();
      wait_end(TMO + 200);
      check(err == 1'b1, "R11 err set on timeout", err, 1);
      check(cs_n && !busy, "R11 select released, idle", {cs_n, busy}, 2);
      repeat (50) @(negedge clk);
      check(n_rd == 0 && we_cnt == 0 && done_cnt == 0, "R11 no read/store/done after abort",
            n_rd + we_cnt + done_cnt, 0);
      check(err == 1'b1, "R11 err sticky", err, 1);
   endtask

   task automatic t_restart_latch();
      logic [NUM-1:0][7:0] cl;
      for (int n = 0; n < NUM; n++) cl[n] = 8'h10 + 8'(3 * n);
      code_list = cl; base_addr = 8'h40; poll_mode = 1'b1;
      salt = 8'h77; respond = 1'b1; conv_cyc = 400;
      clr_stats();
      pulse_start();
      check(err == 1'b0, "R11 err cleared by new start", err, 0);
      base_addr = 8'h80;
      poll_mode = 1'b0;
      repeat (900) @(negedge clk);
      pulse_start();
      wait_end(20000);
      chk_scan_common(cl, 8'h40, 8'h77, "restart");
      check(gap_max < DELAY, "R13 poll mode kept after port change", gap_max, DELAY);
      for (int n = 0; n < NUM; n++) begin
         check(bmem[8'h80 + n] == 8'h00, "R12 R13 no store at new base", bmem[8'h80 + n], 0);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      poll_mode = 1'b0;
      base_addr = '0;
      code_list = '0;
      clr_stats();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_poll_scan();
      t_delay_silent();
      t_delay_early();
      t_timeout();
      t_restart_latch();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule